// File: doc/BRIEF.md
# Serial Receive Path with FIFO and Overrun Lock

This block takes an asynchronous serial line carrying 8N1 frames, recovers each byte with a 16x oversampling receiver, and queues the bytes in a 16-entry FIFO. A CPU reaches the block through a small register port with read and write strobes, a 2-bit address and 16-bit data.

When a frame completes while the FIFO already holds 16 bytes, the block raises a sticky overrun flag. The arriving byte is dropped, and the queued bytes stay as they were. While the flag is up, the receiver stays idle. Software must read the flag as 1 and then write 0 to restart reception. Turning off receive-enable does not touch the flag.

Register map (2-bit address):
- 0: receive data. A read pops one byte.
- 1: control. Bit 0 is receive-enable.
- 2: line status. Bit 0 is the overrun flag.
- 3: fill count in bits 4:0.

Top module: `rxf_rx_top`

## Requirements
- R1: After reset, the control, line status and count registers read 0, and the receive data register reads 0.
- R2: Frames are sampled at 16 clocks per bit, data LSB first. A byte is queued only when its stop bit samples high. A frame with a low stop bit is discarded.
- R3: The FIFO holds up to 16 bytes and returns them in arrival order. Address 3 bits 4:0 report the number queued.
- R4: A read of address 0 returns the oldest byte and removes it. A read of address 0 while the FIFO is empty returns the last byte removed and leaves the count unchanged.
- R5: A frame that completes while the count is 16 sets line status bit 0. That byte is discarded, the count stays 16, and the queued contents are kept.
- R6: While the overrun flag is 1, no frame is received, even when the FIFO has room.
- R7: The flag clears only on a write with bit 0 = 0 after a read of address 2 that returned bit 0 = 1. A write of 0 without that read has no effect, and a write of 1 has no effect.
- R8: While control bit 0 is 0, no frame is received. Changing control bit 0 never changes the overrun flag.
- R9: Line status bits 15:1 always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one oversample tick per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idles high |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the addressed register, combinational |

## Verification
The assertions check on every cycle that:
- the FIFO never takes a byte when full;
- an empty pop leaves the count alone;
- the flag only rises on an overrun event and only falls after the armed read;
- a halted or disabled receiver stays idle;
- an overrun leaves the fill level untouched.

Only the bench scenarios can show the byte values and their order, the discarding of bad-stop frames, the exact frame at which overrun fires, and the full read-then-write clearing sequence at the register port.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned REG_W  = 16;

  localparam logic [ADDR_W-1:0] A_DATA  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd1;
  localparam logic [ADDR_W-1:0] A_LSTAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd3;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/rxf_receiver.sv
module rxf_receiver
  import rxf_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          en_i,
  input  logic          halt_i,
  output logic          done_o,
  output logic [DW-1:0] byte_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned BW = $clog2(DW);
  localparam logic [CW-1:0] HALF = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] shf_q;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shf_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          RX_IDLE: begin
            cnt_q <= '0;
            if (!rx_s && !halt_i) state_q <= RX_START;
          end
          RX_START: begin
            if (cnt_q == HALF) begin
              cnt_q   <= '0;
              bit_q   <= '0;
              state_q <= rx_s ? RX_IDLE : RX_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_DATA: begin
            if (cnt_q == FULL) begin
              cnt_q <= '0;
              shf_q <= {rx_s, shf_q[DW-1:1]};
              if (bit_q == BW'(DW-1)) state_q <= RX_STOP;
              bit_q <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (cnt_q == FULL) begin
              cnt_q <= '0;
              if (rx_s) begin
                done_o  <= 1'b1;
                state_q <= RX_IDLE;
              end else begin
                state_q <= RX_WAIT_HI;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_WAIT_HI: if (rx_s) state_q <= RX_IDLE;
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign byte_o = shf_q;

  AST_HALT_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && state_q == RX_IDLE) |=> state_q == RX_IDLE); // R6
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == RX_IDLE && !done_o)); // R8
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            pop_i,
  output logic [DW-1:0]   rdata_o,
  output logic [$clog2(DEPTH):0] count_o,
  output logic            full_o,
  output logic            empty_o
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;
  logic [DW-1:0] last_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (PW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = empty_o ? last_q : mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop) begin
        rp_q   <= rp_q + 1'b1;
        last_q <= mem_q[rp_q];
      end
      cnt_q <= cnt_q + (PW+1)'(do_push) - (PW+1)'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R3
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> count_o == '0); // R4
endmodule

// File: rtl/rxf_line_status.sv
module rxf_line_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovr_evt_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (ovr_evt_i) begin
      // set wins over a simultaneous clear
      flag_o  <= 1'b1;
      armed_q <= 1'b0;
    end else if (wr_i && !wbit_i && armed_q) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd_i && flag_o) begin
      armed_q <= 1'b1;
    end
  end

  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(armed_q)); // R7
  AST_SET_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(ovr_evt_i)); // R5
endmodule

// File: rtl/rxf_rx_top.sv
module rxf_rx_top
  import rxf_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o
);
  localparam int unsigned CNTW = $clog2(DEPTH) + 1;

  logic            rx_en_q;
  logic            done;
  logic [DW-1:0]   rx_byte;
  logic            push, pop, ovr_evt, ovr_flag;
  logic [DW-1:0]   fifo_rd;
  logic [CNTW-1:0] fifo_cnt;
  logic            fifo_full, fifo_empty;
  logic            ls_rd, ls_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rx_en_q <= 1'b0;
    else if (wr_i && addr_i == A_CTRL) rx_en_q <= wdata_i[0];
  end

  assign push    = done && !fifo_full;
  assign ovr_evt = done && fifo_full;
  assign pop     = rd_i && addr_i == A_DATA;
  assign ls_rd   = rd_i && addr_i == A_LSTAT;
  assign ls_wr   = wr_i && addr_i == A_LSTAT;

  rxf_receiver #(.OVS(OVS), .DW(DW)) u_rx (
    .clk_i (clk_i), .rst_ni (rst_ni), .rx_i (rx_i),
    .en_i (rx_en_q), .halt_i (ovr_flag),
    .done_o (done), .byte_o (rx_byte)
  );

  rxf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .push_i (push), .wdata_i (rx_byte), .pop_i (pop),
    .rdata_o (fifo_rd), .count_o (fifo_cnt),
    .full_o (fifo_full), .empty_o (fifo_empty)
  );

  rxf_line_status u_ls (
    .clk_i (clk_i), .rst_ni (rst_ni), .ovr_evt_i (ovr_evt),
    .rd_i (ls_rd), .wr_i (ls_wr), .wbit_i (wdata_i[0]),
    .flag_o (ovr_flag)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_DATA:  rdata_o = REG_W'(fifo_rd);
      A_CTRL:  rdata_o = REG_W'(rx_en_q);
      A_LSTAT: rdata_o = REG_W'(ovr_flag);
      A_COUNT: rdata_o = REG_W'(fifo_cnt);
      default: rdata_o = '0;
    endcase
  end

  AST_OVR_KEEPS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_evt && !pop) |=> fifo_cnt == $past(fifo_cnt)); // R5
  AST_NO_DONE_WHILE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ovr_flag) && ovr_flag) |-> !done); // R6
endmodule

// File: tb/tb_rxf_rx_top.sv
module tb_rxf_rx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic        rd = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int checks = 0, fails = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  rxf_rx_top dut (
    .clk_i (clk), .rst_ni (rst_n), .rx_i (rx), .rd_i (rd), .wr_i (wr),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic stop_bit = 1'b1);
    logic [9:0] fr;
    fr = {stop_bit, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rx = fr[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); rx = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    reg_rd(2'd1, d); chk("R1 ctrl", d, 16'h0);
    reg_rd(2'd2, d); chk("R1 lstat", d, 16'h0);
    reg_rd(2'd3, d); chk("R1 count", d, 16'h0);
    reg_rd(2'd0, d); chk("R1 data", d, 16'h0);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    reg_wr(2'd1, 16'h1);
    send(8'hA5); send(8'h3C);
    reg_rd(2'd3, d); chk("R3 count two", d, 16'd2);
    reg_rd(2'd0, d); chk("R2 first byte", d, 16'h00A5);
    reg_rd(2'd0, d); chk("R2 second byte", d, 16'h003C);
    reg_rd(2'd3, d); chk("R4 count after pops", d, 16'd0);
  endtask

  task automatic t_empty_read();
    logic [15:0] d;
    reg_rd(2'd0, d); chk("R4 empty read last", d, 16'h003C);
    reg_rd(2'd3, d); chk("R4 empty count", d, 16'd0);
  endtask

  task automatic t_bad_stop();
    logic [15:0] d;
    send(8'h5A, 1'b0);
    reg_rd(2'd3, d); chk("R2 bad stop dropped", d, 16'd0);
    send(8'h81);
    reg_rd(2'd0, d); chk("R2 after bad stop", d, 16'h0081);
  endtask

  task automatic t_disabled();
    logic [15:0] d;
    reg_wr(2'd1, 16'h0);
    send(8'h77);
    reg_rd(2'd3, d); chk("R8 disabled no rx", d, 16'd0);
    reg_wr(2'd1, 16'h1);
  endtask

  task automatic t_overrun();
    logic [15:0] d;
    for (int i = 0; i < 16; i++) send(8'(i*7 + 1));
    reg_rd(2'd3, d); chk("R3 full count", d, 16'd16);
    reg_rd(2'd2, d); chk("R5 no flag at 16", d, 16'h0);
    send(8'hEE);
    reg_wr(2'd2, 16'hFFFF);
    reg_wr(2'd2, 16'h0000);
    reg_rd(2'd2, d); chk("R9 R7 flag only bit0, unread write no effect", d, 16'h0001);
    reg_rd(2'd3, d); chk("R5 count stays 16", d, 16'd16);
  endtask

  task automatic t_blocked();
    logic [15:0] d;
    reg_rd(2'd0, d); chk("R5 oldest kept", d, 16'h0001);
    send(8'h42);
    reg_rd(2'd3, d); chk("R6 no rx while flag", d, 16'd15);
    reg_wr(2'd1, 16'h0);
    reg_rd(2'd2, d); chk("R8 flag kept on disable", d, 16'h0001);
    reg_wr(2'd1, 16'h1);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    reg_rd(2'd2, d);
    reg_wr(2'd2, 16'h0001);
    reg_rd(2'd2, d); chk("R7 write one no effect", d, 16'h0001);
    reg_wr(2'd2, 16'h0000);
    reg_rd(2'd2, d); chk("R7 cleared", d, 16'h0000);
    for (int i = 1; i < 16; i++) begin
      reg_rd(2'd0, d); chk("R3 order kept", d, 16'(8'(i*7 + 1)));
    end
    send(8'hC3);
    reg_rd(2'd3, d); chk("R6 resumes after clear", d, 16'd1);
    reg_rd(2'd0, d); chk("R5 new byte after clear", d, 16'h00C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_empty_read();
    t_bad_stop();
    t_disabled();
    t_overrun();
    t_blocked();
    t_clear();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule